// File: doc/BRIEF.md
# I2C Display Controller Slave Front End

This block is the two-wire serial receiver and transmitter that sits in front of a display controller. It oversamples the bus clock and data lines with the fast system clock, recognises START and STOP, and answers only to its own 7-bit address. The lowest address bit comes from a strap pin. The other end of the block is a set of plain strobes: a command-byte write, a display-RAM byte write, and a fetch-advance pulse for RAM reads.

A write transfer begins with a control byte. Its top bit (continuation) says whether another control byte will follow the next data byte. Its bit 6 (target select) says where the data goes: 1 sends it to display RAM and 0 sends it to the command decoder. Once a control byte arrives with the continuation bit clear, every byte after it is data until the transfer ends. A read transfer returns bytes from the RAM-read port or from the status port. The choice follows the target select of the most recent control byte. The block never drives SDA high: it only asserts an active-low enable for an open-drain pad.

Top module: `i2c_disp_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 011110 followed by the level of `addr_lsb`. Any other address gets no acknowledge, and the rest of that transfer produces no strobe.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits clocked in without a preceding START are ignored and get no acknowledge.
- R3: After each byte it accepts (the address, and each write byte of an addressed write), the block holds `sda_oe` high for the whole high phase of the ninth SCL pulse.
- R4: The first byte after a write address is a control byte. While a control byte has bit 7 = 1, control and data bytes alternate.
- R5: After a control byte with bit 7 = 0, every following byte up to STOP or repeated START is data, including bytes that look like control bytes.
- R6: A data byte raises `ram_wr` for one cycle when the governing control byte had bit 6 = 1, and raises `cmd_wr` when it had bit 6 = 0. The byte appears on `wr_data`. The two strobes are never high together.
- R7: When the address byte's bit 0 is 1, bytes are sent MSB first from the first clock after the address acknowledge. They come from `ram_rd_data` if the last control byte had bit 6 = 1, and from `status_i` otherwise. Each RAM byte fetched produces one `ram_rd_next` pulse.
- R8: When the master does not acknowledge a sent byte, the block releases SDA and fetches no further byte until the next START.
- R9: A repeated START returns the block to the address phase, and the next write byte is parsed as a control byte. A STOP also clears the continuation state.
- R10: Only write bytes that were fully received and acknowledged produce strobes. A byte cut short by STOP produces none.
- R11: `sda_oe` changes only while SCL is low. After reset `sda_oe`, `cmd_wr`, `ram_wr` and `ram_rd_next` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, pad pulls SDA low |
| addr_lsb | input | 1 | Strap giving the address LSB |
| cmd_wr | output | 1 | One-cycle command byte strobe |
| ram_wr | output | 1 | One-cycle display RAM byte strobe |
| wr_data | output | 8 | Byte carried by either write strobe |
| status_i | input | 8 | Status byte returned on reads |
| ram_rd_data | input | 8 | RAM byte returned on reads |
| ram_rd_next | output | 1 | Pulse after a RAM byte is taken |

## Verification
The assertions rely on three properties of the bus. Each SCL phase lasts many system clocks, longer than the synchronizer delay. The master moves SDA during SCL high only to form START or STOP. The master never tries a STOP or START while the slave is pulling the line low. The bench keeps to all three. Its SCL phases are 16 system clocks long. It changes master SDA in the middle of the low phase. It models the bus as a wired AND of master and slave. It forms START and STOP only while the slave has released the line.

// File: rtl/i2cd_pkg.sv
// Shared types for the display-controller bus slave.
package i2cd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RECV,   // shifting in a byte
        ST_ACK,    // slave acknowledge bit
        ST_SEND,   // shifting out a byte
        ST_MACK,   // master acknowledge bit
        ST_SKIP    // not addressed or read ended, wait for START/STOP
    } link_state_t;
endpackage

// File: rtl/i2cd_sync.sv
// Multi-flop synchronizer with edge detection for one bus line.
// Assumes the line is idle at RST_LVL while reset is applied.
module i2cd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    // Shift the raw line through the sync chain plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {(STAGES+1){RST_LVL}};
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cd_cond.sv
// START/STOP detector working on synchronized lines.
// Assumes both lines pass through equal sync delays.
module i2cd_cond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_p,
    output logic stop_p
);
    // A data edge while the clock is high is a bus condition.
    always_comb begin
        start_p = scl_lvl & sda_fall;
        stop_p  = scl_lvl & sda_rise;
    end
endmodule

// File: rtl/i2cd_parse.sv
// Control/data byte parser for write transfers. Steers each acknowledged
// data byte to the command or RAM strobe and remembers the target select.
// Assumes byte_ok pulses once per acknowledged non-address write byte.
module i2cd_parse #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_ok,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              cmd_wr,
    output logic              ram_wr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dc_last
);
    localparam int CO_BIT = BYTE_W - 1;
    localparam int DC_BIT = BYTE_W - 2;

    logic expect_ctrl;
    logic co_more;

    // Track control/data alternation and issue one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_ctrl <= 1'b1;
            co_more     <= 1'b0;
            dc_last     <= 1'b0;
            cmd_wr      <= 1'b0;
            ram_wr      <= 1'b0;
            wr_data     <= '0;
        end else begin
            cmd_wr <= 1'b0;
            ram_wr <= 1'b0;
            if (clear) begin
                expect_ctrl <= 1'b1;
                co_more     <= 1'b0;
            end else if (byte_ok) begin
                if (expect_ctrl) begin
                    expect_ctrl <= 1'b0;
                    co_more     <= byte_in[CO_BIT];
                    dc_last     <= byte_in[DC_BIT];
                end else begin
                    wr_data     <= byte_in;
                    cmd_wr      <= ~dc_last;
                    ram_wr      <= dc_last;
                    expect_ctrl <= co_more;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_disp_slave.sv
// Two-wire bus slave front end for a display controller. Oversamples the
// bus, matches the strapped address, acknowledges, receives write bytes
// for the parser and sends read bytes from status or RAM ports.
// Assumes SCL phases span several system clocks and no clock stretching.
module i2c_disp_slave #(
    parameter int         BYTE_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b011110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_lsb,
    output logic              cmd_wr,
    output logic              ram_wr,
    output logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] status_i,
    input  logic [BYTE_W-1:0] ram_rd_data,
    output logic              ram_rd_next
);
    import i2cd_pkg::*;

    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int N_LINES  = 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [N_LINES-1:0] raw_in, lvl, rise, fall;
    logic scl_lvl, scl_rise, scl_fall, sda_lvl;
    logic start_p, stop_p;

    assign raw_in = {sda_i, scl_i};

    // One synchronizer per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2cd_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(raw_in[g]),
            .level(lvl[g]), .rise(rise[g]), .fall(fall[g])
        );
    end

    assign scl_lvl  = lvl[0];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign sda_lvl  = lvl[1];

    i2cd_cond u_cond (
        .scl_lvl(scl_lvl), .sda_rise(rise[1]), .sda_fall(fall[1]),
        .start_p(start_p), .stop_p(stop_p)
    );

    link_state_t      st;
    logic             is_addr, rw, full, ack_hi, mnack, oe_q, rd_next_q;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] sh, tx_sh, rd_src;
    logic             byte_ok, load_evt, addr_hit, dc_last;

    // Byte acceptance, read fetch and address match decode.
    always_comb begin
        addr_hit = (sh[BYTE_W-1:1] == {ADDR_HI, addr_lsb});
        byte_ok  = (st == ST_ACK) && !is_addr && scl_rise && !ack_hi
                   && !start_p && !stop_p;
        load_evt = scl_fall && ack_hi && !start_p && !stop_p &&
                   (((st == ST_ACK) && rw) || ((st == ST_MACK) && !mnack));
        rd_src   = dc_last ? ram_rd_data : status_i;
    end

    i2cd_parse #(.BYTE_W(BYTE_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .clear(start_p | stop_p),
        .byte_ok(byte_ok), .byte_in(sh),
        .cmd_wr(cmd_wr), .ram_wr(ram_wr), .wr_data(wr_data),
        .dc_last(dc_last)
    );

    // Bit-level link state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            is_addr   <= 1'b0;
            rw        <= 1'b0;
            full      <= 1'b0;
            ack_hi    <= 1'b0;
            mnack     <= 1'b0;
            oe_q      <= 1'b0;
            rd_next_q <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            tx_sh     <= '0;
        end else begin
            rd_next_q <= load_evt & dc_last;
            if (stop_p) begin
                st     <= ST_IDLE;
                oe_q   <= 1'b0;
                ack_hi <= 1'b0;
                full   <= 1'b0;
            end else if (start_p) begin
                st      <= ST_RECV;
                is_addr <= 1'b1;
                rw      <= 1'b0;
                cnt     <= '0;
                full    <= 1'b0;
                oe_q    <= 1'b0;
                ack_hi  <= 1'b0;
            end else begin
                case (st)
                    ST_RECV: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            if (!is_addr || addr_hit) begin
                                oe_q <= 1'b1;
                                st   <= ST_ACK;
                                if (is_addr) rw <= sh[0];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_rise) begin
                            ack_hi <= 1'b1;
                        end else if (scl_fall && ack_hi) begin
                            ack_hi  <= 1'b0;
                            is_addr <= 1'b0;
                            cnt     <= '0;
                            if (load_evt) begin
                                tx_sh <= rd_src;
                                oe_q  <= ~rd_src[BYTE_W-1];
                                st    <= ST_SEND;
                            end else begin
                                oe_q <= 1'b0;
                                st   <= ST_RECV;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) full <= 1'b1;
                        end else if (scl_fall) begin
                            if (full) begin
                                full <= 1'b0;
                                oe_q <= 1'b0;
                                st   <= ST_MACK;
                            end else begin
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                                oe_q  <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            ack_hi <= 1'b1;
                            mnack  <= sda_lvl;
                        end else if (scl_fall && ack_hi) begin
                            ack_hi <= 1'b0;
                            cnt    <= '0;
                            if (load_evt) begin
                                tx_sh <= rd_src;
                                oe_q  <= ~rd_src[BYTE_W-1];
                                st    <= ST_SEND;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe      = oe_q;
    assign ram_rd_next = rd_next_q;
endmodule

// File: rtl/i2cd_checker.sv
// Protocol checker for the display-controller bus slave, bound to the top.
// Assumes bus timing as described in the brief.
module i2cd_checker (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_s,
    input logic                   sda_oe,
    input logic                   cmd_wr,
    input logic                   ram_wr,
    input logic                   rd_next,
    input i2cd_pkg::link_state_t  st
);
    import i2cd_pkg::*;

    // R11: the pad enable only moves while the clock is low
    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R6: command and RAM strobes are exclusive
    assert_wr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && ram_wr));

    // R10: a write strobe is a single-cycle pulse
    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || ram_wr) |=> !(cmd_wr || ram_wr));

    // R3: strobes come from the acknowledge clock high phase
    assert_strobe_ack_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || ram_wr) |-> scl_s);

    // R1: the line is only pulled while addressed
    assert_drive_addressed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st != ST_IDLE && st != ST_SKIP));

    // R7: RAM fetch pulses follow a clock fall
    assert_fetch_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_next |-> !scl_s);
endmodule

bind i2c_disp_slave i2cd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_lvl), .sda_oe(sda_oe),
    .cmd_wr(cmd_wr), .ram_wr(ram_wr), .rd_next(ram_rd_next), .st(st)
);

// File: tb/i2c_disp_slave_tb.sv
module i2c_disp_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int NV         = 8;

    // {strap, addr7, ctrl, data, exp_ack, exp_cmd, exp_ram}
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 7'h3C, 8'h00, 8'h5A, 1'b1, 1'b1, 1'b0},
        {1'b0, 7'h3C, 8'h40, 8'h66, 1'b1, 1'b0, 1'b1},
        {1'b0, 7'h3D, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0},
        {1'b1, 7'h3D, 8'h40, 8'h77, 1'b1, 1'b0, 1'b1},
        {1'b1, 7'h3C, 8'h00, 8'h22, 1'b0, 1'b0, 1'b0},
        {1'b1, 7'h1E, 8'h40, 8'h33, 1'b0, 1'b0, 1'b0},
        {1'b0, 7'h3C, 8'h80, 8'h99, 1'b1, 1'b1, 1'b0},
        {1'b1, 7'h3D, 8'hC0, 8'h0F, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic sda_oe, cmd_wr, ram_wr, ram_rd_next;
    logic [7:0] wr_data;
    logic [7:0] status_v = 8'hC3;
    logic [7:0] ram_q = 8'h5A;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0, n_bad = 0;
    int cmd_n = 0, ram_n = 0, fetch_n = 0;
    logic [7:0] cmd_log [64];
    logic [7:0] ram_log [64];
    bit done = 1'b0;

    i2c_disp_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .addr_lsb(strap), .cmd_wr(cmd_wr),
        .ram_wr(ram_wr), .wr_data(wr_data), .status_i(status_v),
        .ram_rd_data(ram_q), .ram_rd_next(ram_rd_next)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record strobes seen at the outputs.
    always @(posedge clk) begin
        if (rst_n) begin
            if (cmd_wr) begin cmd_log[cmd_n % 64] <= wr_data; cmd_n <= cmd_n + 1; end
            if (ram_wr) begin ram_log[ram_n % 64] <= wr_data; ram_n <= ram_n + 1; end
            if (ram_rd_next) begin ram_q <= ram_q + 8'd1; fetch_n <= fetch_n + 1; end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1); scl = 1'b1; wq(2); sda_m = 1'b0; wq(2); scl = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1); scl = 1'b1; wq(2); sda_m = 1'b1; wq(2);
    endtask

    task automatic clk_bit(input bit b);
        sda_m = b; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; wq(1); scl = 1'b1; wq(1); a1 = !sda_bus;
        wq(1); a2 = !sda_bus; scl = 1'b0; wq(1);
        acked = a1 & a2;
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1); scl = 1'b1; wq(1); b[i] = sda_bus; wq(1); scl = 1'b0; wq(1);
        end
        clk_bit(nack);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        int c0, r0, f0;
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0 && cmd_wr == 1'b0 && ram_wr == 1'b0 && ram_rd_next == 1'b0,
            "R11 reset outputs", int'({sda_oe, cmd_wr, ram_wr, ram_rd_next}), 0);
        rst_n = 1'b1;
        wq(2);
        chk(sda_oe == 1'b0, "R11 idle after reset", sda_oe, 0);

        // Vector table: address match, routing, acknowledge
        for (int v = 0; v < NV; v++) begin
            strap = VEC[v][26];
            wq(2);
            c0 = cmd_n; r0 = ram_n;
            bus_start();
            wr_byte({VEC[v][25:19], 1'b0}, ack);
            chk(ack == VEC[v][2], "R1 address ack", ack, VEC[v][2]);
            wr_byte(VEC[v][18:11], ack);
            chk(ack == VEC[v][2], "R3 control ack", ack, VEC[v][2]);
            wr_byte(VEC[v][10:3], ack);
            chk(ack == VEC[v][2], "R3 data ack", ack, VEC[v][2]);
            bus_stop();
            chk(cmd_n - c0 == int'(VEC[v][1]), "R6 cmd strobes", cmd_n - c0, VEC[v][1]);
            chk(ram_n - r0 == int'(VEC[v][0]), "R6 ram strobes", ram_n - r0, VEC[v][0]);
            if (VEC[v][1]) chk(cmd_log[c0 % 64] == VEC[v][10:3], "R6 cmd data",
                               cmd_log[c0 % 64], VEC[v][10:3]);
            if (VEC[v][0]) chk(ram_log[r0 % 64] == VEC[v][10:3], "R6 ram data",
                               ram_log[r0 % 64], VEC[v][10:3]);
        end
        strap = 1'b0; wq(2);

        // R7 RAM read: last control had target select 1
        strap = 1'b1; wq(2);
        f0 = fetch_n;
        bus_start();
        wr_byte({7'h3D, 1'b1}, ack);
        chk(ack, "R7 read address ack", ack, 1);
        rd_byte(1'b0, rb);
        chk(rb == 8'h5A, "R7 ram byte 0", rb, 8'h5A);
        rd_byte(1'b1, rb);
        chk(rb == 8'h5B, "R7 ram byte 1", rb, 8'h5B);
        wq(1);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        chk(fetch_n - f0 == 2, "R8 no fetch after nack", fetch_n - f0, 2);
        bus_stop();
        strap = 1'b0; wq(2);

        // R7 status read after control byte with select 0
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack);
        wr_byte(8'h00, ack);
        bus_stop();
        f0 = fetch_n;
        bus_start();
        wr_byte({7'h3C, 1'b1}, ack);
        rd_byte(1'b1, rb);
        bus_stop();
        chk(rb == 8'hC3, "R7 status byte", rb, 8'hC3);
        chk(fetch_n == f0, "R7 no ram fetch on status", fetch_n - f0, 0);

        // R4 alternation with continuation set
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack);
        wr_byte(8'h80, ack); wr_byte(8'h01, ack);
        wr_byte(8'hC0, ack); wr_byte(8'h02, ack);
        wr_byte(8'h80, ack); wr_byte(8'h03, ack);
        bus_stop();
        chk(cmd_n - c0 == 2 && ram_n - r0 == 1, "R4 strobe counts",
            (cmd_n - c0) * 16 + (ram_n - r0), 8'h21);
        chk(cmd_log[c0 % 64] == 8'h01 && cmd_log[(c0 + 1) % 64] == 8'h03,
            "R4 cmd bytes", cmd_log[(c0 + 1) % 64], 8'h03);
        chk(ram_log[r0 % 64] == 8'h02, "R4 ram byte", ram_log[r0 % 64], 8'h02);

        // R5 continuation clear: everything after is data
        r0 = ram_n; c0 = cmd_n;
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack);
        wr_byte(8'h40, ack); wr_byte(8'h80, ack); wr_byte(8'hC0, ack); wr_byte(8'h00, ack);
        bus_stop();
        chk(ram_n - r0 == 3 && cmd_n == c0, "R5 data stream count", ram_n - r0, 3);
        chk(ram_log[(r0 + 1) % 64] == 8'hC0, "R5 control-like byte as data",
            ram_log[(r0 + 1) % 64], 8'hC0);

        // R9 repeated START restarts with a control byte
        c0 = cmd_n; r0 = ram_n;
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack);
        wr_byte(8'h00, ack); wr_byte(8'h22, ack);
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack);
        chk(ack, "R9 repeated start address ack", ack, 1);
        wr_byte(8'hC0, ack); wr_byte(8'h33, ack);
        bus_stop();
        chk(cmd_n - c0 == 1, "R9 control byte not a command", cmd_n - c0, 1);
        chk(ram_n - r0 == 1 && ram_log[r0 % 64] == 8'h33, "R9 ram byte after restart",
            ram_log[r0 % 64], 8'h33);

        // R9 STOP clears continuation state
        r0 = ram_n; c0 = cmd_n;
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack); wr_byte(8'h00, ack); wr_byte(8'h10, ack);
        bus_stop();
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack); wr_byte(8'hC0, ack); wr_byte(8'h44, ack);
        bus_stop();
        chk(cmd_n - c0 == 1 && ram_n - r0 == 1 && ram_log[r0 % 64] == 8'h44,
            "R9 stop clears state", ram_log[r0 % 64], 8'h44);

        // R10 / R2 byte cut short by STOP
        r0 = ram_n;
        bus_start();
        wr_byte({7'h3C, 1'b0}, ack); wr_byte(8'h40, ack);
        clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1);
        bus_stop();
        wq(2);
        chk(ram_n == r0, "R10 aborted byte no strobe", ram_n - r0, 0);

        // R2 no START: address bits ignored
        c0 = cmd_n;
        wr_byte({7'h3C, 1'b0}, ack);
        chk(!ack, "R2 no ack without start", ack, 0);
        wr_byte(8'h00, ack); wr_byte(8'h55, ack);
        bus_stop();
        chk(cmd_n == c0, "R2 no strobe without start", cmd_n - c0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule